// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Timing Engine

This block produces the bit-level waveforms of a single-wire serial bus. The bus is open-drain with a pull-up resistor. A host picks one of four commands and pulses a start strobe. The engine then pulls the line low and releases it to a fixed schedule, polls the synchronized line where a slave may answer, and reports the outcome. The four commands are a bus reset with presence detection, a write time slot carrying a 0, a write time slot carrying a 1, and a read time slot.

All durations are whole microseconds. A microsecond tick enable is derived from a clock-frequency parameter, and the tick divider restarts whenever a command is accepted, so every phase lasts an exact number of clock cycles. Presence and read data come from the first low sample seen in a polled window, not from one sample point. Each slot is padded to the same total length whatever the bit value, so the host sees a constant slot time.

After a bus reset has completed, the engine asserts a strong pull-up enable while it is idle. This can power parasite-supplied devices. The enable is removed for the whole of any later transaction.

Top module: `onewire_master`

## Requirements
- R1: Command code 2'b00 (bus reset) drives `line_low_o` high for exactly 500 µs from the cycle after acceptance, then releases the line.
- R2: After the reset pulse the line input, taken through a two-flop synchronizer, is sampled 5, 10, ... 240 µs after release. The first low sample sets `presence_o` and ends polling. If no sample in that window is low, `presence_o` stays 0.
- R3: After reset polling ends, whether early or at 240 µs, the engine stays busy for a further 450 µs. A whole reset therefore lasts 500 µs, plus the time at which polling ended, plus 450 µs.
- R4: `strong_pu_o` is 0 out of reset. It is 1 only while idle after at least one bus reset has completed. It is never 1 while busy and never 1 together with `line_low_o`.
- R5: Command code 2'b10 (write 1) holds the line low for 2 µs. The slot lasts 64 µs in total.
- R6: Command code 2'b01 (write 0) holds the line low for 62 µs. The slot lasts 64 µs in total.
- R7: Command code 2'b11 (read) holds the line low for 2 µs. It then samples the line 7, 12, ... 47 µs after slot start. `rd_bit_o` becomes 0 if any of these samples is low and stays 1 otherwise. The slot always lasts 64 µs.
- R8: A start strobe received while `busy_o` is 1 is ignored. The running transaction keeps its command and its timing, and it produces a single done pulse.
- R9: `busy_o` is 1 from the cycle after acceptance until the end of the transaction. `done_o` is then 1 for exactly one cycle. Each start clears `presence_o` and sets `rd_bit_o` to 1. Both then hold their values until the next start.
- R10: After synchronous reset the outputs are `busy_o`=0, `done_o`=0, `line_low_o`=0, `strong_pu_o`=0, `presence_o`=0 and `rd_bit_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 00 reset, 01 write 0, 10 write 1, 11 read |
| start_i | input | 1 | Start strobe, accepted only while idle |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transaction |
| presence_o | output | 1 | A slave answered the last bus reset |
| rd_bit_o | output | 1 | Bit returned by the last read slot |
| line_low_o | output | 1 | Enable for the open-drain pull-down |
| strong_pu_o | output | 1 | Enable for an active pull-up while idle |
| line_i | input | 1 | Raw bus line level, asynchronous |

## Verification
The assertions assume that `cmd_i` carries a valid code whenever `start_i` is high, and that `line_i` behaves like a wired-AND bus. It must never read high while the engine drives it low. The bench satisfies this by building the line from the engine's pull-down and a modelled slave pull-down. The slave asserts its pull-down only after the engine has released the line and holds it for tens of microseconds, far longer than the synchronizer delay. Slave answers are placed just inside and just outside each polling window to test the window edges.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        CMD_RESET = 2'b00,
        CMD_WR0   = 2'b01,
        CMD_WR1   = 2'b10,
        CMD_READ  = 2'b11
    } owm_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_POLL,
        ST_RST_REC,
        ST_SLOT
    } owm_state_e;

    typedef struct packed {
        logic presence;
        logic rd_bit;
    } owm_result_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
    parameter int unsigned TICKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);
    import owm_pkg::*;

    localparam int unsigned DW = bits_for(TICKS_PER_US);
    localparam logic [DW-1:0] DIV_LAST = DW'(TICKS_PER_US - 1);

    logic [DW-1:0] div_q;

    assign tick_o = (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_hi_o
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], line_i};
        end
    end

    assign line_hi_o = pipe_q[STAGES-1];

endmodule

// File: rtl/owm_sequencer.sv
module owm_sequencer #(
    parameter int unsigned RST_LOW_US   = 500,
    parameter int unsigned PRES_WIN_US  = 240,
    parameter int unsigned REC_US       = 450,
    parameter int unsigned POLL_US      = 5,
    parameter int unsigned SLOT_US      = 64,
    parameter int unsigned SHORT_LOW_US = 2,
    parameter int unsigned READ_WIN_US  = 45
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_i,
    input  logic                  line_hi_i,
    input  logic                  start_i,
    input  owm_pkg::owm_cmd_e     cmd_i,
    output logic                  launch_o,
    output logic                  busy_o,
    output logic                  done_o,
    output owm_pkg::owm_result_t  res_o,
    output logic                  line_low_o,
    output logic                  strong_pu_o
);
    import owm_pkg::*;

    localparam int unsigned MAX_US = max2(max2(RST_LOW_US, PRES_WIN_US), max2(REC_US, SLOT_US));
    localparam int unsigned CW = bits_for(MAX_US);
    localparam int unsigned PW = bits_for(POLL_US);

    localparam logic [CW-1:0] RST_LAST  = CW'(RST_LOW_US - 1);
    localparam logic [CW-1:0] WIN_LAST  = CW'(PRES_WIN_US - 1);
    localparam logic [CW-1:0] REC_LAST  = CW'(REC_US - 1);
    localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_US - 1);
    localparam logic [CW-1:0] SHORT_LEN = CW'(SHORT_LOW_US);
    localparam logic [CW-1:0] WR0_LEN   = CW'(SLOT_US - SHORT_LOW_US);
    localparam logic [CW-1:0] RD_LAST   = CW'(SHORT_LOW_US + READ_WIN_US - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_US - 1);

    owm_state_e   st_q;
    owm_cmd_e     cmd_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] pcnt_q;
    owm_result_t  res_q;
    logic         done_q;
    logic         powered_q;

    logic [CW-1:0] low_len;
    logic          poll_hit;
    logic          rd_sample;

    assign launch_o  = (st_q == ST_IDLE) && start_i;
    assign low_len   = (cmd_q == CMD_WR0) ? WR0_LEN : SHORT_LEN;
    assign poll_hit  = (pcnt_q == POLL_LAST);
    assign rd_sample = (cmd_q == CMD_READ) && (cnt_q >= SHORT_LEN)
                       && (cnt_q <= RD_LAST) && poll_hit;

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            st_q      <= ST_IDLE;
            cmd_q     <= CMD_RESET;
            cnt_q     <= '0;
            pcnt_q    <= '0;
            res_q     <= '{presence: 1'b0, rd_bit: 1'b1};
            powered_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cmd_q  <= cmd_i;
                        cnt_q  <= '0;
                        pcnt_q <= '0;
                        res_q  <= '{presence: 1'b0, rd_bit: 1'b1};
                        st_q   <= (cmd_i == CMD_RESET) ? ST_RST_LOW : ST_SLOT;
                    end
                end
                ST_RST_LOW: begin
                    if (tick_i) begin
                        if (cnt_q == RST_LAST) begin
                            cnt_q  <= '0;
                            pcnt_q <= '0;
                            st_q   <= ST_RST_POLL;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RST_POLL: begin
                    if (tick_i) begin
                        cnt_q  <= cnt_q + 1'b1;
                        pcnt_q <= poll_hit ? '0 : pcnt_q + 1'b1;
                        if (poll_hit && !line_hi_i) begin
                            res_q.presence <= 1'b1;
                            cnt_q          <= '0;
                            st_q           <= ST_RST_REC;
                        end else if (cnt_q == WIN_LAST) begin
                            cnt_q <= '0;
                            st_q  <= ST_RST_REC;
                        end
                    end
                end
                ST_RST_REC: begin
                    if (tick_i) begin
                        if (cnt_q == REC_LAST) begin
                            st_q      <= ST_IDLE;
                            done_q    <= 1'b1;
                            powered_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_SLOT: begin
                    if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q >= SHORT_LEN) begin
                            pcnt_q <= poll_hit ? '0 : pcnt_q + 1'b1;
                        end
                        if (rd_sample && !line_hi_i) begin
                            res_q.rd_bit <= 1'b0;
                        end
                        if (cnt_q == SLOT_LAST) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (st_q != ST_IDLE);
    assign done_o      = done_q;
    assign res_o       = res_q;
    assign line_low_o  = (st_q == ST_RST_LOW) || ((st_q == ST_SLOT) && (cnt_q < low_len));
    assign strong_pu_o = (st_q == ST_IDLE) && powered_q;

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(cmd_q));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(busy_o));

    // R2
    presence_in_poll_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(res_q.presence) |-> $past(st_q == ST_RST_POLL));

    // R7
    rdbit_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(res_q.rd_bit) |-> $past((st_q == ST_SLOT) && (cmd_q == CMD_READ)));

endmodule

// File: rtl/onewire_master.sv
module onewire_master #(
    parameter int unsigned CLK_HZ       = 100_000_000,
    parameter int unsigned RST_LOW_US   = 500,
    parameter int unsigned PRES_WIN_US  = 240,
    parameter int unsigned REC_US       = 450,
    parameter int unsigned POLL_US      = 5,
    parameter int unsigned SLOT_US      = 64,
    parameter int unsigned SHORT_LOW_US = 2,
    parameter int unsigned READ_WIN_US  = 45
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd_i,
    input  logic       start_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       presence_o,
    output logic       rd_bit_o,
    output logic       line_low_o,
    output logic       strong_pu_o,
    input  logic       line_i
);
    import owm_pkg::*;

    localparam int unsigned TICKS_PER_US = CLK_HZ / 1_000_000;

    logic        tick;
    logic        launch;
    logic        line_hi;
    owm_result_t res;

    owm_tick_gen #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .restart_i (launch),
        .tick_o    (tick)
    );

    owm_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .line_i    (line_i),
        .line_hi_o (line_hi)
    );

    owm_sequencer #(
        .RST_LOW_US   (RST_LOW_US),
        .PRES_WIN_US  (PRES_WIN_US),
        .REC_US       (REC_US),
        .POLL_US      (POLL_US),
        .SLOT_US      (SLOT_US),
        .SHORT_LOW_US (SHORT_LOW_US),
        .READ_WIN_US  (READ_WIN_US)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .line_hi_i   (line_hi),
        .start_i     (start_i),
        .cmd_i       (owm_cmd_e'(cmd_i)),
        .launch_o    (launch),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .res_o       (res),
        .line_low_o  (line_low_o),
        .strong_pu_o (strong_pu_o)
    );

    assign presence_o = res.presence;
    assign rd_bit_o   = res.rd_bit;

    // R4
    pullup_vs_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(strong_pu_o && line_low_o));

    // R4
    pullup_idle_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !strong_pu_o);

    // R1
    low_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        line_low_o |-> busy_o);

endmodule

// File: tb/onewire_master_bench.sv
`timescale 1ns/1ps
module onewire_master_bench;

    localparam int CLK_HZ = 10_000_000;
    localparam int CPU    = 10;
    localparam int US_NS  = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmd = 2'b00;
    logic       start = 1'b0;
    logic       busy, done, presence, rd_bit, line_low, spu;
    logic       slave_low = 1'b0;
    logic       line;

    always #5 clk = ~clk;

    assign line = !(line_low || slave_low);

    onewire_master #(.CLK_HZ(CLK_HZ)) u_onewire_master (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .start_i     (start),
        .busy_o      (busy),
        .done_o      (done),
        .presence_o  (presence),
        .rd_bit_o    (rd_bit),
        .line_low_o  (line_low),
        .strong_pu_o (spu),
        .line_i      (line)
    );

    int tests = 0;
    int fails = 0;
    int busy_cnt, low_cnt, done_cnt, spu_busy_cnt, overlap_cnt;

    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (line_low) low_cnt++;
        if (done) done_cnt++;
        if (spu && busy) spu_busy_cnt++;
        if (spu && line_low) overlap_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        busy_cnt = 0; low_cnt = 0; done_cnt = 0; spu_busy_cnt = 0; overlap_cnt = 0;
    endtask

    task automatic arm_slave(input int delay_us, input int dur_us);
        fork
            begin
                @(posedge line_low);
                @(negedge line_low);
                #(delay_us * US_NS);
                slave_low = 1'b1;
                #(dur_us * US_NS);
                slave_low = 1'b0;
            end
        join_none
    endtask

    task automatic run_cmd(input logic [1:0] c);
        @(negedge clk);
        clear_counts();
        cmd = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 line_low", line_low, 0);
        check("R10 strong_pu", spu, 0);
        check("R10 presence", presence, 0);
        check("R10 rd_bit", rd_bit, 1);
    endtask

    task automatic t_reset_answer();
        arm_slave(30, 120);
        run_cmd(2'b00);
        check("R1 reset low cycles", low_cnt, 500 * CPU);
        check("R2 presence seen", presence, 1);
        check("R3 reset busy early end", busy_cnt, (500 + 35 + 450) * CPU);
        check("R9 done pulses", done_cnt, 1);
        check("R4 pullup idle after reset", spu, 1);
        check("R4 pullup while busy", spu_busy_cnt, 0);
        check("R1 line released", line_low, 0);
        repeat (50) @(negedge clk);
        check("R9 presence held", presence, 1);
    endtask

    task automatic t_reset_silent();
        run_cmd(2'b00);
        check("R2 no presence", presence, 0);
        check("R3 reset busy full window", busy_cnt, (500 + 240 + 450) * CPU);
    endtask

    task automatic t_reset_late();
        arm_slave(242, 60);
        run_cmd(2'b00);
        check("R2 late answer ignored", presence, 0);
        check("R3 late busy", busy_cnt, (500 + 240 + 450) * CPU);
    endtask

    task automatic t_reset_edge();
        arm_slave(237, 60);
        run_cmd(2'b00);
        check("R2 answer at last sample", presence, 1);
        check("R3 edge busy", busy_cnt, (500 + 240 + 450) * CPU);
    endtask

    task automatic t_write1();
        run_cmd(2'b10);
        check("R5 write1 low", low_cnt, 2 * CPU);
        check("R5 write1 total", busy_cnt, 64 * CPU);
        check("R4 no pullup in slot", spu_busy_cnt, 0);
        check("R4 no overlap", overlap_cnt, 0);
        check("R9 write1 done", done_cnt, 1);
    endtask

    task automatic t_write0();
        run_cmd(2'b01);
        check("R6 write0 low", low_cnt, 62 * CPU);
        check("R6 write0 total", busy_cnt, 64 * CPU);
    endtask

    task automatic t_read_idle_bus();
        run_cmd(2'b11);
        check("R7 read low", low_cnt, 2 * CPU);
        check("R7 read returns 1", rd_bit, 1);
        check("R7 read total", busy_cnt, 64 * CPU);
    endtask

    task automatic t_read_early();
        arm_slave(8, 25);
        run_cmd(2'b11);
        check("R7 early zero", rd_bit, 0);
        check("R7 total after early low", busy_cnt, 64 * CPU);
    endtask

    task automatic t_read_late();
        arm_slave(46, 10);
        run_cmd(2'b11);
        check("R7 late low ignored", rd_bit, 1);
    endtask

    task automatic t_read_edge();
        arm_slave(44, 10);
        run_cmd(2'b11);
        check("R7 low at last sample", rd_bit, 0);
        repeat (50) @(negedge clk);
        check("R9 rd_bit held", rd_bit, 0);
    endtask

    task automatic t_ignore_start();
        @(negedge clk);
        clear_counts();
        cmd = 2'b01;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        cmd = 2'b00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R8 low unchanged", low_cnt, 62 * CPU);
        check("R8 total unchanged", busy_cnt, 64 * CPU);
        check("R8 single done", done_cnt, 1);
        check("R8 idle after", busy, 0);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_reset_answer();
        t_reset_silent();
        t_reset_late();
        t_reset_edge();
        t_write1();
        t_write0();
        t_read_idle_bus();
        t_read_early();
        t_read_late();
        t_read_edge();
        t_ignore_start();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule